// File: doc/BRIEF.md
# Double-to-Half Narrowing Converter

This block turns one 64-bit binary64 floating-point operand into a 16-bit half-precision encoding. Each conversion also yields a per-conversion exception flag vector. A conversion is presented with `in_valid` and appears, registered, on the next clock edge. The rounding direction and four mode controls travel with the operand in the same cycle, so every conversion can run under its own settings.

The controls select among several behaviours. One flushes subnormal inputs and tiny results to zero. One replaces every NaN with a single canonical NaN. One switches to an alternative half format that has no infinities and no NaNs and uses the top exponent code for ordinary finite values. The last forces the underflow flag on every tiny result. Rounding carries into the exponent field, so a subnormal can round up into the smallest normal value and a large normal can round up into overflow.

Top module: `f64_to_f16_narrow`

## Requirements
- R1: When `in_valid` is high, `res_bits` and `exc_flags` show that operand's conversion after the next rising clock edge, and `out_valid` is high for exactly that cycle. When `in_valid` is low, `res_bits` and `exc_flags` keep their values and `out_valid` is low. Reset clears all three outputs to zero.
- R2: With `rnd_mode` = 0 (round to nearest), a finite value in the normal half range is rounded to the nearest representable value. An exact tie goes to the value whose last fraction bit is 0.
- R3: `rnd_mode` = 1 rounds toward +infinity, 2 rounds toward -infinity and 3 rounds toward zero. A directed mode increases the magnitude only when discarded bits are nonzero and the sign matches the direction. Any nonzero discarded part sets the inexact flag.
- R4: Outside the alternative format, a finite result whose biased exponent would reach 31 overflows and sets both the overflow flag and the inexact flag. The result is signed infinity (exponent all ones, fraction 0) when the mode rounds away from zero in the sign's direction. Otherwise it is the signed largest normal value (0x7BFF magnitude).
- R5: A result is tiny when the exact value is below 2^-14 before rounding. A tiny result is encoded as a subnormal and may round up to 0x0400. A tiny result sets the underflow flag when it is inexact, and also whenever `unf_trap_en` is high.
- R6: With `ftz_en` high, a subnormal operand gives a signed zero and sets the input-denormal flag. With `ftz_en` high, a tiny result gives a signed zero and sets only the flushed flag.
- R7: Outside the alternative format, a NaN with `dnan_en` high gives 0x7E00. A NaN with `dnan_en` low keeps its sign, has result bits 14:9 set, and copies operand bits 50:42 into result bits 8:0. Operand bit 51 clear marks a signalling NaN, which sets the invalid flag. A quiet NaN sets no flag.
- R8: With `alt_half_en` high, any NaN gives a signed zero and sets invalid. An infinity gives the sign with all 15 other bits set, and sets invalid. Biased exponent 31 holds finite values. A finite value beyond that range gives sign with 0x7FFF and sets only the invalid flag.
- R9: Outside the alternative format, an infinity gives a signed half infinity with no flag. A zero operand gives a signed zero with no flag in every mode.
- R10: Flag bit positions: 0 invalid, 1 overflow, 2 underflow, 3 inexact, 4 input-denormal, 5 flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| op_bits | input | 64 | binary64 operand |
| rnd_mode | input | 2 | Rounding direction (0 nearest, 1 +inf, 2 -inf, 3 zero) |
| ftz_en | input | 1 | Flush subnormal inputs and tiny results to zero |
| dnan_en | input | 1 | Replace NaN results with the canonical NaN |
| alt_half_en | input | 1 | Alternative half format with no infinity or NaN |
| unf_trap_en | input | 1 | Underflow trap enable, which raises underflow on every tiny result |
| out_valid | output | 1 | A conversion result is on the outputs this cycle |
| res_bits | output | 16 | Half-precision result |
| exc_flags | output | 6 | Exception flags of the last conversion |

## Verification
The hardest cases to reach are at the edges of the rounding windows. One is a value just below 2^-14 that rounds up into the smallest normal while still counting as tiny. Another is a value just below the overflow threshold that only a directed mode pushes over. A third is a NaN payload whose upper fraction bits must survive narrowing. Uniform random operands almost never land on these. The stimulus therefore runs a directed list of operands built on those boundaries under every rounding mode and several control combinations. It then runs random operands whose exponent is biased toward the narrow band around the half range.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  parameter int unsigned SRC_EXP_W  = 11;
  parameter int unsigned SRC_FRAC_W = 52;
  parameter int unsigned DST_EXP_W  = 5;
  parameter int unsigned DST_FRAC_W = 10;

  localparam int unsigned SRC_W    = 1 + SRC_EXP_W + SRC_FRAC_W;
  localparam int unsigned DST_W    = 1 + DST_EXP_W + DST_FRAC_W;
  localparam int          SRC_BIAS = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int          DST_BIAS = (1 << (DST_EXP_W - 1)) - 1;
  localparam int          SH_MAX   = DST_FRAC_W + 3;
  localparam int          DST_EMAX     = (1 << DST_EXP_W) - 2;
  localparam int          DST_EMAX_ALT = (1 << DST_EXP_W) - 1;

  localparam int FL_W   = 6;
  localparam int FL_INV = 0;
  localparam int FL_OVF = 1;
  localparam int FL_UNF = 2;
  localparam int FL_INX = 3;
  localparam int FL_IDC = 4;
  localparam int FL_FLU = 5;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_PINF = 2'd1,
    RM_MINF = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUB,
    CL_NORM,
    CL_INF,
    CL_QNAN,
    CL_SNAN
  } class_e;

  typedef struct packed {
    logic                  sign;
    class_e                cls;
    logic [SRC_EXP_W-1:0]  exp;
    logic [SRC_FRAC_W-1:0] frac;
  } src_t;
endpackage

// File: rtl/nrw_classify.sv
module nrw_classify
  import nrw_pkg::*;
(
  input  logic [SRC_W-1:0] op,
  input  logic             fz,
  output src_t             d,
  output logic             idc
);
  logic exp_zero, exp_ones, frac_zero;

  always_comb begin
    d.sign    = op[SRC_W-1];
    d.exp     = op[SRC_W-2 -: SRC_EXP_W];
    d.frac    = op[SRC_FRAC_W-1:0];
    exp_zero  = (d.exp == '0);
    exp_ones  = (d.exp == '1);
    frac_zero = (d.frac == '0);
    idc       = 1'b0;
    if (exp_ones) begin
      if (frac_zero)                d.cls = CL_INF;
      else if (d.frac[SRC_FRAC_W-1]) d.cls = CL_QNAN;
      else                          d.cls = CL_SNAN;
    end else if (exp_zero) begin
      if (frac_zero) begin
        d.cls = CL_ZERO;
      end else if (fz) begin
        d.cls = CL_ZERO;
        idc   = 1'b1;
      end else begin
        d.cls = CL_SUB;
      end
    end else begin
      d.cls = CL_NORM;
    end
  end
endmodule

// File: rtl/nrw_round.sv
module nrw_round
  import nrw_pkg::*;
(
  input  src_t             d,
  input  logic [1:0]       rmode,
  input  logic             fz,
  input  logic             ahp,
  input  logic             ufe,
  output logic [DST_W-1:0] bits,
  output logic [FL_W-1:0]  flags
);
  localparam int SIG_W   = SRC_FRAC_W + 1;
  localparam int WIDE_W  = SIG_W + SH_MAX;
  localparam int KEEP_W  = DST_FRAC_W + 1;
  localparam int HE_W    = SRC_EXP_W + 2;
  localparam int SH_W    = $clog2(SH_MAX + 1);
  localparam int EXPF_W  = DST_EXP_W + 1;
  localparam int SUM_W   = EXPF_W + DST_FRAC_W;
  localparam logic signed [HE_W-1:0] HE_ONE   = 1;
  localparam logic signed [HE_W-1:0] HE_FLOOR = 1 - SH_MAX;
  localparam logic signed [HE_W-1:0] HE_GAP   = SRC_BIAS - DST_BIAS;

  logic signed [HE_W-1:0] he;
  logic                   tiny, rbit, sticky, inx, up, otinf, pre_ovf, post_ovf;
  logic [SH_W-1:0]        sh;
  logic [SIG_W-1:0]       sig;
  logic [WIDE_W-1:0]      wide;
  logic [KEEP_W-1:0]      kept;
  logic [KEEP_W:0]        m12;
  logic [EXPF_W-1:0]      ebase, elim;
  logic [SUM_W-1:0]       sum;

  // rebias and align the significand to the half quantum
  always_comb begin
    he   = $signed({2'b00, d.exp}) - HE_GAP;
    sig  = (d.cls == CL_SUB) ? {1'b0, d.frac} : {1'b1, d.frac};
    tiny = (d.cls == CL_SUB) || (he < HE_ONE);
    if (!tiny)
      sh = '0;
    else if (d.cls == CL_SUB || he < HE_FLOOR)
      sh = SH_W'(SH_MAX);
    else
      sh = SH_W'(HE_ONE - he);
    wide   = {sig, {SH_MAX{1'b0}}} >> sh;
    kept   = wide[WIDE_W-1 -: KEEP_W];
    rbit   = wide[WIDE_W-KEEP_W-1];
    sticky = |wide[WIDE_W-KEEP_W-2:0];
    inx    = rbit | sticky;
  end

  // rounding decision per direction
  always_comb begin
    case (rmode_e'(rmode))
      RM_NEAR: begin up = rbit & (sticky | kept[0]); otinf = 1'b1;    end
      RM_PINF: begin up = inx & ~d.sign;             otinf = ~d.sign; end
      RM_MINF: begin up = inx & d.sign;              otinf = d.sign;  end
      default: begin up = 1'b0;                      otinf = 1'b0;    end
    endcase
  end

  // pack: exponent minus one plus significand with hidden bit lets carries ripple
  always_comb begin
    m12      = {1'b0, kept} + (KEEP_W+1)'(up);
    elim     = ahp ? EXPF_W'(DST_EMAX_ALT) : EXPF_W'(DST_EMAX);
    pre_ovf  = !tiny && (he > $signed({{(HE_W-EXPF_W){1'b0}}, elim}));
    ebase    = tiny ? '0 : EXPF_W'(he - HE_ONE);
    sum      = {ebase, {DST_FRAC_W{1'b0}}} + SUM_W'(m12);
    post_ovf = sum[SUM_W-1 -: EXPF_W] > elim;
  end

  always_comb begin
    flags = '0;
    if (fz && tiny) begin
      bits          = {d.sign, {(DST_W-1){1'b0}}};
      flags[FL_FLU] = 1'b1;
    end else if (pre_ovf || post_ovf) begin
      if (ahp) begin
        bits          = {d.sign, {(DST_W-1){1'b1}}};
        flags[FL_INV] = 1'b1;
      end else begin
        bits          = otinf ? {d.sign, {DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}}
                              : {d.sign, {(DST_EXP_W-1){1'b1}}, 1'b0, {DST_FRAC_W{1'b1}}};
        flags[FL_OVF] = 1'b1;
        flags[FL_INX] = 1'b1;
      end
    end else begin
      bits          = {d.sign, sum[DST_W-2:0]};
      flags[FL_INX] = inx;
      flags[FL_UNF] = tiny && (inx || ufe);
    end
  end
endmodule

// File: rtl/f64_to_f16_narrow.sv
module f64_to_f16_narrow
  import nrw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] op_bits,
  input  logic [1:0]       rnd_mode,
  input  logic             ftz_en,
  input  logic             dnan_en,
  input  logic             alt_half_en,
  input  logic             unf_trap_en,
  output logic             out_valid,
  output logic [DST_W-1:0] res_bits,
  output logic [FL_W-1:0]  exc_flags
);
  src_t             d;
  logic             idc;
  logic [DST_W-1:0] rnd_bits, res_d, res_q;
  logic [FL_W-1:0]  rnd_flags, flags_d, flags_q;
  logic             vld_q, ld_en;

  nrw_classify u_cls (
    .op  (op_bits),
    .fz  (ftz_en),
    .d   (d),
    .idc (idc)
  );

  nrw_round u_rnd (
    .d     (d),
    .rmode (rnd_mode),
    .fz    (ftz_en),
    .ahp   (alt_half_en),
    .ufe   (unf_trap_en),
    .bits  (rnd_bits),
    .flags (rnd_flags)
  );

  // special-class selection
  always_comb begin
    res_d   = rnd_bits;
    flags_d = rnd_flags;
    case (d.cls)
      CL_ZERO: begin
        res_d          = {d.sign, {(DST_W-1){1'b0}}};
        flags_d        = '0;
        flags_d[FL_IDC] = idc;
      end
      CL_INF: begin
        flags_d = '0;
        if (alt_half_en) begin
          res_d           = {d.sign, {(DST_W-1){1'b1}}};
          flags_d[FL_INV] = 1'b1;
        end else begin
          res_d = {d.sign, {DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};
        end
      end
      CL_QNAN, CL_SNAN: begin
        flags_d = '0;
        if (alt_half_en) begin
          res_d           = {d.sign, {(DST_W-1){1'b0}}};
          flags_d[FL_INV] = 1'b1;
        end else begin
          if (dnan_en)
            res_d = {1'b0, {(DST_EXP_W+1){1'b1}}, {(DST_FRAC_W-1){1'b0}}};
          else
            res_d = {d.sign, {(DST_EXP_W+1){1'b1}},
                     d.frac[SRC_FRAC_W-2 -: DST_FRAC_W-1]};
          flags_d[FL_INV] = (d.cls == CL_SNAN);
        end
      end
      default: ;
    endcase
  end

  assign ld_en = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (ld_en) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign res_bits  = res_q;
  assign exc_flags = flags_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_bits) && $stable(exc_flags))); // R1
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_flags[FL_OVF]) |-> exc_flags[FL_INX]); // R4
  AST_UNF_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_flags[FL_UNF]) |-> (res_bits[DST_W-2:DST_FRAC_W+1] == '0)); // R5
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_flags[FL_FLU]) |-> (res_bits[DST_W-2:0] == '0)); // R6
endmodule

// File: tb/sim_f64_to_f16_narrow.sv
`timescale 1ns/1ps
module sim_f64_to_f16_narrow;
  logic        clk, rst_n, in_valid;
  logic [63:0] op_bits;
  logic [1:0]  rnd_mode;
  logic        ftz_en, dnan_en, alt_half_en, unf_trap_en;
  logic        out_valid;
  logic [15:0] res_bits;
  logic [5:0]  exc_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_r;
  logic [5:0]  exp_f;
  logic        exp_v;
  string       exp_tag;

  f64_to_f16_narrow u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_bits(op_bits),
    .rnd_mode(rnd_mode), .ftz_en(ftz_en), .dnan_en(dnan_en),
    .alt_half_en(alt_half_en), .unf_trap_en(unf_trap_en),
    .out_valid(out_valid), .res_bits(res_bits), .exc_flags(exc_flags)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural model: exact integer scaling, no guard/round/sticky structure
  function automatic void model(input logic [63:0] op, input logic [1:0] rm,
                                input bit fz, dn, ahp, ufe,
                                output logic [15:0] r, output logic [5:0] fl,
                                output string tag);
    bit s = op[63];
    int e = int'(op[62:52]);
    logic [51:0] f = op[51:0];
    longint unsigned m, kept, rem, halfv, mag;
    int ex, flo, q, sh, bexp, maxb;
    bit tiny, gt, eq, nz, up, otinf;
    fl = '0;
    if (e == 2047) begin
      if (f == 0) begin
        if (ahp) begin r = {s, 15'h7FFF}; fl[0] = 1; tag = "R8"; end
        else     begin r = {s, 15'h7C00}; tag = "R9"; end
      end else begin
        if (ahp) begin r = {s, 15'h0}; fl[0] = 1; tag = "R8"; end
        else begin
          r = dn ? 16'h7E00 : {s, 6'b111111, f[50:42]};
          fl[0] = !f[51];
          tag = "R7";
        end
      end
      return;
    end
    if (e == 0 && f == 0) begin r = {s, 15'h0}; tag = "R9"; return; end
    if (e == 0 && fz) begin r = {s, 15'h0}; fl[4] = 1; tag = "R6"; return; end
    m   = (e == 0) ? longint'(f) : (longint'(f) | (64'd1 << 52));
    ex  = (e == 0) ? -1074 : e - 1075;
    flo = (e == 0) ? -1100 : e - 1023;
    tiny = flo < -14;
    if (tiny && fz) begin r = {s, 15'h0}; fl[5] = 1; tag = "R6"; return; end
    q  = (flo - 10 < -24) ? -24 : flo - 10;
    sh = q - ex;
    if (sh > 60) begin
      kept = 0; gt = 0; eq = 0; nz = (m != 0);
    end else begin
      kept  = m >> sh;
      rem   = m - (kept << sh);
      halfv = 64'd1 << (sh - 1);
      gt = rem > halfv; eq = rem == halfv; nz = rem != 0;
    end
    case (rm)
      2'd0: begin up = gt || (eq && kept[0]); otinf = 1;  end
      2'd1: begin up = nz && !s;              otinf = !s; end
      2'd2: begin up = nz && s;               otinf = s;  end
      default: begin up = 0;                  otinf = 0;  end
    endcase
    mag = kept + longint'(up);
    if (mag >= 2048) begin mag = mag >> 1; q = q + 1; end
    bexp = (mag < 1024) ? 0 : q + 25;
    maxb = ahp ? 31 : 30;
    if (bexp > maxb) begin
      if (ahp) begin r = {s, 15'h7FFF}; fl[0] = 1; tag = "R8"; end
      else begin
        r = otinf ? {s, 15'h7C00} : {s, 15'h7BFF};
        fl[1] = 1; fl[3] = 1; tag = "R4";
      end
      return;
    end
    r = {s, bexp[4:0], mag[9:0]};
    fl[3] = nz;
    fl[2] = tiny && (nz || ufe);
    if (tiny) tag = "R5";
    else if (ahp && bexp == 31) tag = "R8";
    else tag = (rm == 0) ? "R2" : "R3";
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_v || res_bits !== exp_r || exc_flags !== exp_f) begin
      errors++;
      $display("FAIL %s/R10 valid=%b/%b res=%h/%h flags=%b/%b",
               exp_v ? exp_tag : "R1", out_valid, exp_v, res_bits, exp_r,
               exc_flags, exp_f);
    end
  endtask

  // one clock: check what the last cycle produced, then drive the next
  task automatic step(input bit v, input logic [63:0] op, input logic [1:0] rm,
                      input bit fz, dn, ahp, ufe);
    @(negedge clk);
    compare();
    in_valid = v; op_bits = op; rnd_mode = rm;
    ftz_en = fz; dnan_en = dn; alt_half_en = ahp; unf_trap_en = ufe;
    exp_v = v;
    if (v) model(op, rm, fz, dn, ahp, ufe, exp_r, exp_f, exp_tag);
  endtask

  logic [63:0] dir [24];

  initial begin
    in_valid = 0; op_bits = '0; rnd_mode = '0;
    ftz_en = 0; dnan_en = 0; alt_half_en = 0; unf_trap_en = 0;
    exp_v = 0; exp_r = '0; exp_f = '0; exp_tag = "R1";
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state, R1
    compare();

    dir[0]  = 64'h3FF0000000000000; // 1.0
    dir[1]  = 64'h3FF0020000000000; // tie, even stays
    dir[2]  = 64'h3FF0060000000000; // tie, odd rounds up
    dir[3]  = 64'hC00F0FFFFFFFFFFF; // inexact negative
    dir[4]  = 64'h40EFFC0000000000; // largest normal
    dir[5]  = 64'h40EFFE0000000000; // tie into overflow
    dir[6]  = 64'h40EFFC0000000001; // just above largest normal
    dir[7]  = 64'hC202A05F20000000; // huge negative
    dir[8]  = 64'h3F10000000000000; // smallest normal
    dir[9]  = 64'h3F0FFFFFFFFFFFFF; // tiny, rounds to smallest normal
    dir[10] = 64'h3E70000000000000; // smallest subnormal
    dir[11] = 64'h3E60000000000000; // half of it: tie
    dir[12] = 64'hBE68000000000000; // 1.5 of half smallest subnormal
    dir[13] = 64'h3F00000000000000; // exact subnormal
    dir[14] = 64'h0000000000000001; // binary64 subnormal
    dir[15] = 64'h7FF0000000000000; // +inf
    dir[16] = 64'hFFF0000000000000; // -inf
    dir[17] = 64'h7FFABCDE00000123; // quiet NaN with payload
    dir[18] = 64'hFFF5550000000000; // signalling NaN, negative
    dir[19] = 64'h0000000000000000;
    dir[20] = 64'h8000000000000000;
    dir[21] = 64'h40FFFC0000000000; // top of alternative range
    dir[22] = 64'h4100000000000000; // beyond alternative range
    dir[23] = 64'h40F0000000000000; // exponent 31 in alternative format

    for (int c = 0; c < 5; c++) begin
      for (int rm = 0; rm < 4; rm++) begin
        for (int i = 0; i < 24; i++) begin
          case (c)
            0: step(1, dir[i], 2'(rm), 0, 0, 0, 0);
            1: step(1, dir[i], 2'(rm), 1, 0, 0, 1);
            2: step(1, dir[i], 2'(rm), 0, 1, 0, 1);
            3: step(1, dir[i], 2'(rm), 0, 0, 1, 0);
            default: step(1, dir[i], 2'(rm), 1, 1, 1, 1);
          endcase
        end
      end
    end

    // idle cycles with changing inputs must not disturb outputs, R1
    step(1, dir[2], 2'd0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, dir[i + 5], 2'(i), 1, 1, 1, 1);
    step(1, dir[9], 2'd1, 0, 0, 0, 0);

    // random operands, exponent biased around the half range
    for (int n = 0; n < 6000; n++) begin
      logic [63:0] op;
      int sel = int'($urandom % 8);
      int e;
      case (sel)
        0: e = 0;
        1: e = 2047;
        2, 3, 4, 5: e = 990 + int'($urandom % 55);
        default: e = int'($urandom % 2048);
      endcase
      op = {1'($urandom), 11'(e), 20'($urandom), 32'($urandom)};
      step(($urandom % 8) != 0, op, 2'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    end
    step(0, '0, 2'd0, 0, 0, 0, 0);
    step(0, '0, 2'd0, 0, 0, 0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule